// File: doc/BRIEF.md
# Host / Co-processor Mailbox Latches

This block passes bytes between a host processor and a sound co-processor in the same clock domain. It holds two sets of byte latches that never share storage. One set is written by the host and read by the co-processor. The other set is written by the co-processor and read by the host. Neither set is kept in the RAM that the co-processor shares with a DSP.

The host sees a window of four ports, selected by a 2-bit index. The co-processor sees a 16-byte register page at 0xF0..0xFF. Every write the co-processor makes is copied, one cycle later, onto a RAM write port with the same address and byte. This lets the DSP see whatever the co-processor stored, including its register writes. A control register in the page can zero the inbound latches in pairs.

All read data and the RAM write port are registered and appear one cycle after the request.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, all eight latches read as zero from both sides. `ram_we`, `cop_rd_ram`, `host_rdata` and `cop_rdata` are all zero.
- R2: A host write to index k changes only inbound latch k. It never raises `ram_we`.
- R3: A host read of index k returns outbound latch k on `host_rdata` in the next cycle. RAM contents never appear there.
- R4: A co-processor write to 0xF4+k (k = 0..3) loads outbound latch k.
- R5: A co-processor read of 0xF4+k returns inbound latch k on `cop_rdata` in the next cycle, with `cop_rd_ram` low.
- R6: A co-processor write to 0xF1 clears inbound latches 0 and 1 when data bit 4 is 1. It clears inbound latches 2 and 3 when data bit 5 is 1. The other data bits leave the latches unchanged.
- R7: When a host write and a clear from 0xF1 target the same inbound latch in the same cycle, the latch takes the host byte.
- R8: Every co-processor write, in the page or outside it, raises `ram_we` for one cycle in the next cycle, with the same address and byte. Writes to page addresses other than 0xF1 and 0xF4..0xF7 change no latch.
- R9: A co-processor read of any address outside 0xF4..0xF7 raises `cop_rd_ram` in the next cycle, with `cop_rdata` zero.
- R10: A read in the same cycle as a write to the same latch returns the value the latch held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and co-processor |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_idx | input | 2 | Host port index |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| cop_wr_en | input | 1 | Co-processor write strobe |
| cop_rd_en | input | 1 | Co-processor read strobe |
| cop_addr | input | 16 | Co-processor address |
| cop_wdata | input | 8 | Co-processor write byte |
| cop_rdata | output | 8 | Registered co-processor read byte from the latches |
| cop_rd_ram | output | 1 | Registered flag: serve this read from RAM |
| ram_we | output | 1 | Forwarded RAM write strobe |
| ram_addr | output | 16 | Forwarded RAM write address |
| ram_wdata | output | 8 | Forwarded RAM write byte |

## Verification
The bench checks that a host write that lands in the same cycle as a pair clear survives it. A design that gives the clear priority would read back zero. It writes 0xF1 with only the unrelated bits set. A decoder that treats any control write as a full clear would wipe all four inbound latches. It also checks that host writes never reach the RAM port and that non-port page writes leave every latch alone. A design that mirrors latches into RAM would fail both checks. Finally, it reads a latch in the same cycle the latch is written. This catches a read path that bypasses the latch and returns the new byte early.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_DATA_W    = 8;
  localparam int MB_PORTS     = 4;
  localparam int MB_ADDR_W    = 16;
  localparam int MB_PAGE_BASE = 'h00F0;
  localparam int MB_PORT_OFF  = 4;
  localparam int MB_CTRL_OFF  = 1;
  localparam int MB_CLR_BIT   = 4;
endpackage

// File: rtl/mbox_host_window.sv
module mbox_host_window #(
  parameter int PORTS = 4,
  parameter int IDX_W = $clog2(PORTS)
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  output logic [PORTS-1:0] port_we
);
  for (genvar i = 0; i < PORTS; i++) begin : g_we
    assign port_we[i] = wr_en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/mbox_cop_decode.sv
module mbox_cop_decode #(
  parameter int ADDR_W    = 16,
  parameter int PORTS     = 4,
  parameter int PAGE_BASE = 'h00F0,
  parameter int PORT_OFF  = 4,
  parameter int CTRL_OFF  = 1,
  parameter int IDX_W     = $clog2(PORTS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        clr_bits,
  output logic [PORTS-1:0]  port_we,
  output logic [PORTS-1:0]  clr_mask,
  output logic              port_hit,
  output logic [IDX_W-1:0]  port_idx
);
  localparam int TAG_W = ADDR_W - 4;
  localparam logic [TAG_W-1:0] PAGE_TAG = TAG_W'(PAGE_BASE >> 4);
  localparam int HALF = PORTS / 2;

  logic       in_page;
  logic [3:0] nib;
  logic [3:0] nib_rel;
  logic       ctrl_hit;

  always_comb begin
    in_page  = (addr[ADDR_W-1:4] == PAGE_TAG);
    nib      = addr[3:0];
    nib_rel  = nib - 4'(PORT_OFF);
    port_hit = in_page && (nib >= 4'(PORT_OFF)) && (nib_rel < 4'(PORTS));
    port_idx = nib_rel[IDX_W-1:0];
    ctrl_hit = wr_en && in_page && (nib == 4'(CTRL_OFF));
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_port
    localparam int GRP = i / HALF;
    assign port_we[i]  = wr_en && port_hit && (port_idx == IDX_W'(i));
    assign clr_mask[i] = ctrl_hit && clr_bits[GRP];
  end
endmodule

// File: rtl/mbox_latch_bank.sv
module mbox_latch_bank #(
  parameter int DATA_W = 8,
  parameter int PORTS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PORTS-1:0]              host_we,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic [PORTS-1:0]              cop_we,
  input  logic [DATA_W-1:0]             cop_wdata,
  input  logic [PORTS-1:0]              clr_mask,
  output logic [PORTS-1:0][DATA_W-1:0]  h2c,
  output logic [PORTS-1:0][DATA_W-1:0]  c2h
);
  for (genvar i = 0; i < PORTS; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)               h2c[i] <= '0;
      else if (host_we[i])   h2c[i] <= host_wdata;
      else if (clr_mask[i])  h2c[i] <= '0;
    end

    always_ff @(posedge clk) begin
      if (rst)             c2h[i] <= '0;
      else if (cop_we[i])  c2h[i] <= cop_wdata;
    end

    assert_host_wins_R7: assert property (@(posedge clk) disable iff (rst)
      host_we[i] |=> h2c[i] == $past(host_wdata));
    assert_pair_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_mask[i] && !host_we[i]) |=> h2c[i] == '0);
    assert_inbound_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!host_we[i] && !clr_mask[i]) |=> $stable(h2c[i]));
    assert_outbound_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !cop_we[i] |=> $stable(c2h[i]));
  end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int DATA_W    = MB_DATA_W,
  parameter int PORTS     = MB_PORTS,
  parameter int ADDR_W    = MB_ADDR_W,
  parameter int PAGE_BASE = MB_PAGE_BASE,
  parameter int PORT_OFF  = MB_PORT_OFF,
  parameter int CTRL_OFF  = MB_CTRL_OFF,
  parameter int CLR_BIT   = MB_CLR_BIT,
  parameter int IDX_W     = $clog2(PORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cop_wr_en,
  input  logic              cop_rd_en,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic [DATA_W-1:0] cop_wdata,
  output logic [DATA_W-1:0] cop_rdata,
  output logic              cop_rd_ram,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  logic [PORTS-1:0]             host_we;
  logic [PORTS-1:0]             cop_we;
  logic [PORTS-1:0]             clr_mask;
  logic                         port_hit;
  logic [IDX_W-1:0]             port_idx;
  logic [PORTS-1:0][DATA_W-1:0] h2c;
  logic [PORTS-1:0][DATA_W-1:0] c2h;

  mbox_host_window #(.PORTS(PORTS), .IDX_W(IDX_W)) u_host (
    .wr_en(host_wr_en), .idx(host_idx), .port_we(host_we)
  );

  mbox_cop_decode #(
    .ADDR_W(ADDR_W), .PORTS(PORTS), .PAGE_BASE(PAGE_BASE),
    .PORT_OFF(PORT_OFF), .CTRL_OFF(CTRL_OFF), .IDX_W(IDX_W)
  ) u_dec (
    .wr_en(cop_wr_en), .addr(cop_addr),
    .clr_bits(cop_wdata[CLR_BIT +: 2]),
    .port_we(cop_we), .clr_mask(clr_mask),
    .port_hit(port_hit), .port_idx(port_idx)
  );

  mbox_latch_bank #(.DATA_W(DATA_W), .PORTS(PORTS)) u_bank (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_wdata(host_wdata),
    .cop_we(cop_we), .cop_wdata(cop_wdata),
    .clr_mask(clr_mask), .h2c(h2c), .c2h(c2h)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd_en) begin
      host_rdata <= c2h[host_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cop_rdata  <= '0;
      cop_rd_ram <= 1'b0;
    end else begin
      cop_rd_ram <= cop_rd_en && !port_hit;
      if (cop_rd_en) cop_rdata <= port_hit ? h2c[port_idx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= cop_wr_en;
      if (cop_wr_en) begin
        ram_addr  <= cop_addr;
        ram_wdata <= cop_wdata;
      end
    end
  end

  assert_host_no_ram_R2: assert property (@(posedge clk) disable iff (rst)
    !cop_wr_en |=> !ram_we);
  assert_forward_R8: assert property (@(posedge clk) disable iff (rst)
    cop_wr_en |=> (ram_we && ram_addr == $past(cop_addr) && ram_wdata == $past(cop_wdata)));
  assert_ram_sel_zero_R9: assert property (@(posedge clk) disable iff (rst)
    cop_rd_ram |-> cop_rdata == '0);
  assert_ram_sel_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !cop_rd_en |=> !cop_rd_ram);
endmodule

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [1:0]  host_idx = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        cop_wr_en = 0, cop_rd_en = 0;
  logic [15:0] cop_addr = 0;
  logic [7:0]  cop_wdata = 0;
  logic [7:0]  cop_rdata;
  logic        cop_rd_ram;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbox_bridge u_dut (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_wr_en(cop_wr_en), .cop_rd_en(cop_rd_en), .cop_addr(cop_addr),
    .cop_wdata(cop_wdata), .cop_rdata(cop_rdata), .cop_rd_ram(cop_rd_ram),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1; host_idx = k; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic host_rd(input logic [1:0] k, output logic [7:0] d);
    @(negedge clk);
    host_rd_en = 1; host_idx = k;
    @(negedge clk);
    host_rd_en = 0; d = host_rdata;
  endtask

  // returns forwarded {we, addr, data} seen one cycle after the write
  task automatic cop_wr(input logic [15:0] a, input logic [7:0] d, output logic [24:0] fwd);
    @(negedge clk);
    cop_wr_en = 1; cop_addr = a; cop_wdata = d;
    @(negedge clk);
    cop_wr_en = 0; fwd = {ram_we, ram_addr, ram_wdata};
  endtask

  task automatic cop_rd(input logic [15:0] a, output logic [7:0] d, output logic sel);
    @(negedge clk);
    cop_rd_en = 1; cop_addr = a;
    @(negedge clk);
    cop_rd_en = 0; d = cop_rdata; sel = cop_rd_ram;
  endtask

  task automatic fill_inbound();
    host_wr(0, 8'h11); host_wr(1, 8'h22); host_wr(2, 8'h33); host_wr(3, 8'h44);
  endtask

  task automatic check_inbound(input string req, input logic [31:0] exp);
    logic [7:0] d; logic s;
    for (int k = 0; k < 4; k++) begin
      cop_rd(16'h00F4 + 16'(k), d, s);
      check(req, {8'h0, d}, {8'h0, exp[8*k +: 8]});
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 ram_we", {15'h0, ram_we}, 16'h0);
    check("R1 cop_rd_ram", {15'h0, cop_rd_ram}, 16'h0);
    check("R1 host_rdata", {8'h0, host_rdata}, 16'h0);
    check("R1 cop_rdata", {8'h0, cop_rdata}, 16'h0);
    check_inbound("R1 inbound", 32'h0);
    for (int k = 0; k < 4; k++) begin
      host_rd(2'(k), d);
      check("R1 outbound", {8'h0, d}, 16'h0);
    end
  endtask

  task automatic t_host_to_cop();
    logic [7:0] d; logic s;
    @(negedge clk);
    host_wr_en = 1; host_idx = 2; host_wdata = 8'hA5;
    @(negedge clk);
    host_wr_en = 0;
    check("R2 no ram write", {15'h0, ram_we}, 16'h0);
    check_inbound("R2 only latch 2", 32'h00A5_0000);
    cop_rd(16'h00F6, d, s);
    check("R5 rdata", {8'h0, d}, 16'h00A5);
    check("R5 rd_ram low", {15'h0, s}, 16'h0);
  endtask

  task automatic t_cop_to_host();
    logic [24:0] f; logic [7:0] d;
    cop_wr(16'h00F5, 8'h3C, f);
    check("R4 forward we", {15'h0, f[24]}, 16'h1);
    check("R4 forward addr", f[23:8], 16'h00F5);
    check("R4 forward data", {8'h0, f[7:0]}, 16'h003C);
    host_rd(1, d);
    check("R3 host sees latch 1", {8'h0, d}, 16'h003C);
    host_rd(0, d);
    check("R3 latch 0 untouched", {8'h0, d}, 16'h0);
    host_rd(3, d);
    check("R3 latch 3 untouched", {8'h0, d}, 16'h0);
  endtask

  task automatic t_ctrl_clear();
    logic [24:0] f;
    fill_inbound();
    cop_wr(16'h00F1, 8'h10, f);
    check("R6 forward", {f[24], f[23:8] ^ 16'h00F1, 8'(f[7:0])} == 25'h1_0000_10 ? 16'h1 : 16'h0, 16'h1);
    check_inbound("R6 bit4 clears 0,1", 32'h4433_0000);
    fill_inbound();
    cop_wr(16'h00F1, 8'h20, f);
    check_inbound("R6 bit5 clears 2,3", 32'h0000_2211);
    fill_inbound();
    cop_wr(16'h00F1, 8'hCF, f);
    check_inbound("R6 other bits no effect", 32'h4433_2211);
  endtask

  task automatic t_collision();
    fill_inbound();
    @(negedge clk);
    host_wr_en = 1; host_idx = 0; host_wdata = 8'h77;
    cop_wr_en = 1; cop_addr = 16'h00F1; cop_wdata = 8'h30;
    @(negedge clk);
    host_wr_en = 0; cop_wr_en = 0;
    check_inbound("R7 host write wins", 32'h0000_0077);
  endtask

  task automatic t_passthrough();
    logic [24:0] f; logic [7:0] d;
    fill_inbound();
    cop_wr(16'h00F0, 8'h99, f);
    check("R8 F0 forwarded", {f[24], f[23:8] == 16'h00F0, f[7:0] == 8'h99} == 3'b111 ? 16'h1 : 16'h0, 16'h1);
    cop_wr(16'h00FA, 8'h55, f);
    check("R8 FA forwarded", {f[24], f[23:8] == 16'h00FA, f[7:0] == 8'h55} == 3'b111 ? 16'h1 : 16'h0, 16'h1);
    cop_wr(16'h1234, 8'h66, f);
    check("R8 outside page forwarded", {f[24], f[23:8] == 16'h1234, f[7:0] == 8'h66} == 3'b111 ? 16'h1 : 16'h0, 16'h1);
    cop_wr(16'h01F4, 8'h5A, f);
    check_inbound("R8 inbound untouched", 32'h4433_2211);
    host_rd(1, d);
    check("R8 outbound 1 untouched", {8'h0, d}, 16'h003C);
    host_rd(0, d);
    check("R8 outbound 0 untouched", {8'h0, d}, 16'h0);
    @(negedge clk);
    check("R8 single-cycle we", {15'h0, ram_we}, 16'h0);
  endtask

  task automatic t_ram_select();
    logic [7:0] d; logic s;
    cop_rd(16'h00F2, d, s);
    check("R9 F2 rd_ram", {15'h0, s}, 16'h1);
    check("R9 F2 rdata zero", {8'h0, d}, 16'h0);
    cop_rd(16'h0200, d, s);
    check("R9 outside page rd_ram", {15'h0, s}, 16'h1);
    cop_rd(16'h00F8, d, s);
    check("R9 F8 rd_ram", {15'h0, s}, 16'h1);
    cop_rd(16'h00F7, d, s);
    check("R9 F7 latch read", {15'h0, s}, 16'h0);
    check("R5 F7 data", {8'h0, d}, 16'h0044);
  endtask

  task automatic t_same_cycle();
    logic [24:0] f; logic [7:0] d; logic s;
    cop_wr(16'h00F7, 8'h40, f);
    @(negedge clk);
    cop_wr_en = 1; cop_addr = 16'h00F7; cop_wdata = 8'h41;
    host_rd_en = 1; host_idx = 3;
    @(negedge clk);
    cop_wr_en = 0; host_rd_en = 0;
    check("R10 host old value", {8'h0, host_rdata}, 16'h0040);
    host_rd(3, d);
    check("R10 host new value", {8'h0, d}, 16'h0041);
    @(negedge clk);
    host_wr_en = 1; host_idx = 2; host_wdata = 8'hEE;
    cop_rd_en = 1; cop_addr = 16'h00F6;
    @(negedge clk);
    host_wr_en = 0; cop_rd_en = 0;
    check("R10 cop old value", {8'h0, cop_rdata}, 16'h0033);
    cop_rd(16'h00F6, d, s);
    check("R10 cop new value", {8'h0, d}, 16'h00EE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_host_to_cop();
    t_cop_to_host();
    t_ctrl_clear();
    t_collision();
    t_passthrough();
    t_ram_select();
    t_same_cycle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule